// File: doc/BRIEF.md
# Programmable Interval Counter

This block is one down-counter of configurable width (16 bits by default) driven from a host byte bus. The host first writes a control word to choose how the count is loaded and which of six counting behaviours the counter follows. It then writes the starting count as one or two bytes. The counter decrements on every system clock edge where `cnt_tick` is high. A `gate` input either pauses the count or triggers it, depending on the behaviour chosen. The result appears on the single output pin `out_pin`.

The six behaviours are:
- Mode 0: terminal-count flag.
- Mode 1: retriggerable one-shot.
- Mode 2: periodic one-tick pulse.
- Mode 3: square wave.
- Mode 4: strobe started by the count write.
- Mode 5: strobe started by the gate.

Two address bits select a register. Only the counter at select 0 and the control word at select 3 are present. Writes to the other selects are dropped. No count readback is provided, so the host observes the block only through `out_pin`.

Top module: `interval_timer`

## Requirements
- R1: After reset, `out_pin` is 1 and no count is loaded. Until a control word is written, the block behaves as mode 0 with low-then-high count loading.
- R2: A write to select 3 is taken as a control word only when bits [7:6] are 00, bits [5:4] are not 00 and bit 0 is 0. Writes to selects 1 and 2, and control words failing those tests, change nothing.
- R3: Control word layout: bits [5:4] choose count loading (01 = low byte only, upper byte zero; 10 = high byte only, lower byte zero; 11 = low byte then high byte). Bits [3:1] choose the mode 0..5, with codes 6 and 7 acting as modes 2 and 3.
- R4: Mode 0: writing the control word drives `out_pin` to 0. Once the count N is complete, the first tick loads it and `out_pin` rises after N further counting ticks, then stays high.
- R5: Mode 1: a rising gate edge, seen after a count is written, loads N on the next tick and drives `out_pin` low for N ticks. A new rising edge during the pulse reloads N and extends the pulse.
- R6: Mode 2: after the load tick, `out_pin` repeats a pattern of period N ticks. It is low for exactly the one tick at which the count reaches 1, after which N is reloaded.
- R7: Mode 3: `out_pin` is high for ceil(N/2) ticks and low for floor(N/2) ticks, repeating with period N.
- R8: A low `gate` stops counting in modes 0, 2, 3 and 4. In modes 2 and 3 a low gate also forces `out_pin` high, and the next rising edge restarts the count from N on the following tick.
- R9: In modes 4 and 5, `out_pin` goes low for exactly one tick once N counting ticks have followed the load, and it does so only once per load. Mode 4 loads on the count write. Mode 5 loads on a gate rising edge and ignores the gate level.
- R10: With low-then-high loading, the low byte stops counting (and in mode 0 forces `out_pin` low). The high byte restarts the count with the new value.
- R11: A count of 0 stands for 2^CNT_W (65536 by default).
- R12: The counter only loads and counts on clock edges where `cnt_tick` is 1.
- R13: The smallest valid count is 1 in modes 0, 1, 4 and 5, and 2 in modes 2 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe, one cycle per byte |
| addr | input | 2 | Register select: 0 counter, 3 control word |
| wdata | input | 8 | Host write byte |
| cnt_tick | input | 1 | Counting clock enable |
| gate | input | 1 | Gate: level enable or edge trigger, by mode |
| out_pin | output | 1 | Counter output |

## Verification
The bench builds the block with the default 16-bit counter. At that width, a count of zero takes 65537 cycles to reach its terminal state, so the full-range case of R11 can be checked exactly at its boundary. The default width also keeps the odd and even half-periods of the square wave and the minimum counts of every mode reachable within a few cycles. Small random counts in the periodic and strobe modes are checked on every cycle against closed-form expected waveforms.

// File: rtl/itv_pkg.sv
package itv_pkg;

    typedef enum logic [2:0] {
        M_TC      = 3'd0,
        M_ONESHOT = 3'd1,
        M_RATE    = 3'd2,
        M_SQUARE  = 3'd3,
        M_SWSTB   = 3'd4,
        M_HWSTB   = 3'd5
    } mode_e;

    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_LO   = 2'd1,
        ACC_HI   = 2'd2,
        ACC_LOHI = 2'd3
    } acc_e;

    localparam logic [1:0] SEL_COUNT = 2'd0;
    localparam logic [1:0] SEL_CTRL  = 2'd3;

    // codes 6 and 7 fold onto the periodic modes
    function automatic mode_e decode_mode(input logic [2:0] code);
        case (code)
            3'd6:    return M_RATE;
            3'd7:    return M_SQUARE;
            default: return mode_e'(code);
        endcase
    endfunction

endpackage

// File: rtl/itv_host_if.sv
module itv_host_if
    import itv_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [1:0]            addr,
    input  logic [BYTE_W-1:0]     wdata,
    output logic                  ev_ctrl,
    output mode_e                 ev_mode,
    output logic                  ev_halt,
    output logic                  ev_load,
    output logic [2*BYTE_W-1:0]   ev_val
);

    typedef struct packed {
        acc_e              acc;
        logic              pend;
        logic [BYTE_W-1:0] lo;
    } host_st_t;

    localparam host_st_t RST = '{acc: ACC_LOHI, pend: 1'b0, lo: {BYTE_W{1'b0}}};

    host_st_t s_d, s_q;
    logic     ctrl_ok;

    always_comb begin
        s_d     = s_q;
        ev_ctrl = 1'b0;
        ev_mode = M_TC;
        ev_halt = 1'b0;
        ev_load = 1'b0;
        ev_val  = {2*BYTE_W{1'b0}};
        ctrl_ok = (wdata[7:6] == 2'b00) && (wdata[5:4] != 2'b00) && !wdata[0];
        if (wr_en && addr == SEL_CTRL && ctrl_ok) begin
            ev_ctrl   = 1'b1;
            ev_mode   = decode_mode(wdata[3:1]);
            s_d.acc   = acc_e'(wdata[5:4]);
            s_d.pend  = 1'b0;
        end else if (wr_en && addr == SEL_COUNT) begin
            case (s_q.acc)
                ACC_LO: begin
                    ev_load = 1'b1;
                    ev_val  = {{BYTE_W{1'b0}}, wdata};
                end
                ACC_HI: begin
                    ev_load = 1'b1;
                    ev_val  = {wdata, {BYTE_W{1'b0}}};
                end
                default: begin
                    if (!s_q.pend) begin
                        s_d.lo   = wdata;
                        s_d.pend = 1'b1;
                        ev_halt  = 1'b1;
                    end else begin
                        s_d.pend = 1'b0;
                        ev_load  = 1'b1;
                        ev_val   = {wdata, s_q.lo};
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= RST;
        else        s_q <= s_d;
    end

    // R10: the second byte of a low-then-high pair always completes a load
    a_r10_high_completes: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == SEL_COUNT && s_q.acc == ACC_LOHI && s_q.pend) |-> ev_load);

    // R10: a low byte leaves the pair waiting for its high byte
    a_r10_low_waits: assert property (@(posedge clk) disable iff (!rst_n)
        ev_halt |=> (s_q.pend && s_q.acc == ACC_LOHI));

endmodule

// File: rtl/itv_gate_edge.sv
module itv_gate_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic gate,
    output logic gate_rise
);

    logic gate_d, gate_q;

    always_comb begin
        gate_d    = gate;
        gate_rise = gate && !gate_q;
    end

    // reset high so a gate held high out of reset is not an edge
    always_ff @(posedge clk) begin
        if (!rst_n) gate_q <= 1'b1;
        else        gate_q <= gate_d;
    end

endmodule

// File: rtl/itv_core.sv
module itv_core
    import itv_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             gate,
    input  logic             gate_rise,
    input  logic             ev_ctrl,
    input  mode_e            ev_mode,
    input  logic             ev_halt,
    input  logic             ev_load,
    input  logic [CNT_W-1:0] ev_val,
    output logic             out
);

    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};
    localparam logic [CNT_W-1:0] CNT_NIL = {CNT_W{1'b0}};

    typedef struct packed {
        mode_e            mode;
        logic             out;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] rld;
        logic             arm;
        logic             trig;
        logic             halt;
        logic             run;
        logic             have;
        logic             fired;
    } core_st_t;

    localparam core_st_t RST = '{mode: M_TC, out: 1'b1, cnt: CNT_NIL, rld: CNT_NIL,
                                 arm: 1'b0, trig: 1'b0, halt: 1'b0, run: 1'b0,
                                 have: 1'b0, fired: 1'b0};

    core_st_t         s_d, s_q;
    logic [CNT_W:0]   full_w;
    logic [CNT_W-1:0] lo_len, hi_len, cnt_m1;
    logic             is_trig, is_per, restart;

    always_comb begin
        s_d     = s_q;
        // zero stands for the full 2^CNT_W range
        full_w  = (s_q.rld == CNT_NIL) ? {1'b1, CNT_NIL} : {1'b0, s_q.rld};
        lo_len  = full_w[CNT_W:1];
        hi_len  = lo_len + {{(CNT_W-1){1'b0}}, full_w[0]};
        cnt_m1  = s_q.cnt - CNT_ONE;
        is_trig = (s_q.mode == M_ONESHOT) || (s_q.mode == M_HWSTB);
        is_per  = (s_q.mode == M_RATE) || (s_q.mode == M_SQUARE);
        restart = gate_rise && s_q.have && (is_trig || is_per);

        if (tick && !s_q.halt) begin
            if (s_q.arm || s_q.trig) begin
                s_d.cnt   = (s_q.mode == M_SQUARE) ? hi_len : s_q.rld;
                s_d.run   = 1'b1;
                s_d.arm   = 1'b0;
                s_d.trig  = 1'b0;
                s_d.fired = 1'b0;
                s_d.out   = !((s_q.mode == M_TC) || (s_q.mode == M_ONESHOT));
            end else if (s_q.run && !(restart && is_per)) begin
                case (s_q.mode)
                    M_TC: if (gate) begin
                        s_d.cnt = cnt_m1;
                        if (cnt_m1 == CNT_NIL) s_d.out = 1'b1;
                    end
                    M_ONESHOT: begin
                        s_d.cnt = cnt_m1;
                        if (cnt_m1 == CNT_NIL) s_d.out = 1'b1;
                    end
                    M_RATE: if (gate) begin
                        if (s_q.cnt == CNT_ONE) begin
                            s_d.cnt = s_q.rld;
                            s_d.out = 1'b1;
                        end else begin
                            s_d.cnt = cnt_m1;
                            s_d.out = (cnt_m1 != CNT_ONE);
                        end
                    end
                    M_SQUARE: if (gate) begin
                        if (s_q.cnt == CNT_ONE) begin
                            s_d.out = !s_q.out;
                            s_d.cnt = s_q.out ? lo_len : hi_len;
                        end else begin
                            s_d.cnt = cnt_m1;
                        end
                    end
                    default: begin
                        if (!s_q.out) s_d.out = 1'b1;
                        if (s_q.mode == M_HWSTB || gate) begin
                            s_d.cnt = cnt_m1;
                            if (cnt_m1 == CNT_NIL && !s_q.fired) begin
                                s_d.out   = 1'b0;
                                s_d.fired = 1'b1;
                            end
                        end
                    end
                endcase
            end
        end

        if (is_per && s_q.run && !gate) s_d.out = 1'b1;

        if (ev_halt) begin
            s_d.halt = 1'b1;
            if (s_q.mode == M_TC) s_d.out = 1'b0;
        end
        if (ev_load) begin
            s_d.rld  = ev_val;
            s_d.halt = 1'b0;
            s_d.have = 1'b1;
            if (!is_trig) s_d.arm = 1'b1;
            if (s_q.mode == M_TC) s_d.out = 1'b0;
        end
        if (restart) begin
            if (is_trig) s_d.trig = 1'b1;
            else         s_d.arm  = 1'b1;
        end

        if (ev_ctrl) begin
            s_d.mode  = ev_mode;
            s_d.out   = (ev_mode != M_TC);
            s_d.arm   = 1'b0;
            s_d.trig  = 1'b0;
            s_d.halt  = 1'b0;
            s_d.run   = 1'b0;
            s_d.have  = 1'b0;
            s_d.fired = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= RST;
        else        s_q <= s_d;
    end

    assign out = s_q.out;

    a_r4_ctrl_drives_low: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_ctrl && ev_mode == M_TC) |=> !out);

    a_r6_single_low_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.mode == M_RATE && s_q.run && !s_q.out && tick && gate && !s_q.halt && !ev_ctrl)
        |=> out);

    a_r8_gate_low_high: assert property (@(posedge clk) disable iff (!rst_n)
        ((s_q.mode == M_RATE || s_q.mode == M_SQUARE) && s_q.run && !gate && !ev_ctrl)
        |=> out);

    a_r9_strobe_one_tick: assert property (@(posedge clk) disable iff (!rst_n)
        ((s_q.mode == M_SWSTB || s_q.mode == M_HWSTB) && !s_q.out && tick && !s_q.halt && !ev_ctrl)
        |=> out);

    a_r10_halt_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.halt |=> $stable(s_q.cnt));

endmodule

// File: rtl/interval_timer.sv
module interval_timer
    import itv_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [1:0]           addr,
    input  logic [CNT_W/2-1:0]   wdata,
    input  logic                 cnt_tick,
    input  logic                 gate,
    output logic                 out_pin
);

    localparam int BYTE_W = CNT_W / 2;

    logic             ev_ctrl, ev_halt, ev_load, gate_rise;
    mode_e            ev_mode;
    logic [CNT_W-1:0] ev_val;

    itv_host_if #(.BYTE_W(BYTE_W)) u_host (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .ev_ctrl (ev_ctrl),
        .ev_mode (ev_mode),
        .ev_halt (ev_halt),
        .ev_load (ev_load),
        .ev_val  (ev_val)
    );

    itv_gate_edge u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .gate      (gate),
        .gate_rise (gate_rise)
    );

    itv_core #(.CNT_W(CNT_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (cnt_tick),
        .gate      (gate),
        .gate_rise (gate_rise),
        .ev_ctrl   (ev_ctrl),
        .ev_mode   (ev_mode),
        .ev_halt   (ev_halt),
        .ev_load   (ev_load),
        .ev_val    (ev_val),
        .out       (out_pin)
    );

endmodule

// File: tb/tb_interval_timer.sv
module tb_interval_timer;

    localparam int CLK_PERIOD = 10;
    localparam int WDOG       = 190000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic       cnt_tick = 1'b1;
    logic       gate = 1'b1;
    logic       out_pin;

    int  n_total = 0;
    int  n_bad   = 0;
    bit  done    = 1'b0;

    interval_timer dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .cnt_tick (cnt_tick),
        .gate     (gate),
        .out_pin  (out_pin)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // expected output k load-relative counting ticks after the arming edge
    function automatic bit exp_out(input int m, input int n, input int k);
        int p;
        case (m)
            0, 1: return k >= n + 1;
            2: begin p = (k - 1) % n; return p != n - 1; end
            3: begin p = (k - 1) % n; return p < (n + 1) / 2; end
            default: return k != n + 1;
        endcase
    endfunction

    task automatic chk(input bit got, input bit exp, input string tag);
        n_total++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: out_pin=%0b expected %0b at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic wreg(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wctrl(input int m, input int acc);
        wreg(2'd3, {2'b00, acc[1:0], m[2:0], 1'b0});
    endtask

    task automatic load16(input int v);
        wreg(2'd0, v[7:0]);
        wreg(2'd0, v[15:8]);
    endtask

    task automatic run(input string tag, input int m, input int n, input int cycles);
        for (int k = 1; k <= cycles; k++) begin
            @(negedge clk);
            chk(out_pin, exp_out(m, n, k), tag);
        end
    endtask

    initial begin
        repeat (WDOG) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete");
            $display("test done: total=%0d bad=%0d", n_total, n_bad);
            $finish;
        end
    end

    initial begin
        int tk, dec, m, n;
        bit loaded;
        void'($urandom(32'h5eed_1234));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_pin, 1'b1, "R1 reset level");

        // R1: default loading and mode before any control word
        load16(5);
        run("R1 default mode 0", 0, 5, 8);

        // R4: terminal-count flag
        wctrl(0, 3);
        chk(out_pin, 1'b0, "R4 control word low");
        load16(9);
        run("R4 count 9", 0, 9, 12);
        load16(1);
        run("R13 mode 0 count 1", 0, 1, 4);

        // R12: tick only every other cycle
        wctrl(0, 3);
        load16(6);
        tk = 0;
        for (int e = 1; e <= 20; e++) begin
            cnt_tick = (e % 2 == 0);
            @(negedge clk);
            if (cnt_tick) tk++;
            chk(out_pin, exp_out(0, 6, tk), "R12 tick enable");
        end
        cnt_tick = 1'b1;

        // R8: gate low pauses mode 0
        wctrl(0, 3);
        load16(6);
        loaded = 1'b0; dec = 0;
        for (int e = 1; e <= 14; e++) begin
            gate = !(e >= 3 && e <= 5);
            @(negedge clk);
            if (!loaded) loaded = 1'b1;
            else if (gate) dec++;
            chk(out_pin, dec >= 6, "R8 gate pause mode 0");
        end
        gate = 1'b1;

        // R2: writes that must be dropped, while mode 0 counts 8
        wctrl(0, 3);
        load16(8);
        for (int k = 1; k <= 12; k++) begin
            if (k == 2) begin wr_en = 1'b1; addr = 2'd1; wdata = 8'h00; end
            if (k == 3) begin wr_en = 1'b1; addr = 2'd2; wdata = 8'h00; end
            if (k == 4) begin wr_en = 1'b1; addr = 2'd3; wdata = 8'b01_11_010_0; end
            if (k == 5) begin wr_en = 1'b1; addr = 2'd3; wdata = 8'b00_00_010_0; end
            if (k == 6) begin wr_en = 1'b1; addr = 2'd3; wdata = 8'b00_11_010_1; end
            @(negedge clk);
            wr_en = 1'b0;
            chk(out_pin, exp_out(0, 8, k), "R2 ignored writes");
        end

        // R3: single-byte loading
        wctrl(4, 1);
        wreg(2'd0, 8'd3);
        run("R3 low byte only", 4, 3, 6);
        wctrl(0, 2);
        wreg(2'd0, 8'd1);
        run("R3 high byte only", 0, 256, 260);

        // R11: zero means full range
        wctrl(0, 2);
        wreg(2'd0, 8'd0);
        for (int k = 1; k <= 65537; k++) begin
            @(negedge clk);
            if (k >= 65535) chk(out_pin, k == 65537, "R11 zero count");
        end

        // R6 / R13: rate generator
        wctrl(2, 3);
        load16(5);
        run("R6 rate 5", 2, 5, 16);
        load16(2);
        run("R13 rate minimum 2", 2, 2, 6);

        // R7: square wave, odd and even, and code 7 alias (R3)
        wctrl(3, 3);
        load16(7);
        run("R7 square 7", 3, 7, 21);
        load16(6);
        run("R7 square 6", 3, 6, 12);
        wreg(2'd3, 8'b00_11_111_0);
        load16(5);
        run("R3 code 7 as square", 3, 5, 15);

        // R8: gate low in rate mode forces high and restarts
        wctrl(2, 3);
        load16(4);
        run("R6 rate 4", 2, 4, 6);
        gate = 1'b0;
        repeat (3) begin
            @(negedge clk);
            chk(out_pin, 1'b1, "R8 gate low forces high");
        end
        gate = 1'b1;
        @(negedge clk);
        chk(out_pin, 1'b1, "R8 restart edge");
        run("R8 restart from N", 2, 4, 9);

        // R5: one-shot with retrigger
        gate = 1'b0;
        wctrl(1, 3);
        chk(out_pin, 1'b1, "R5 idle high");
        load16(6);
        repeat (4) begin
            @(negedge clk);
            chk(out_pin, 1'b1, "R5 waits for trigger");
        end
        gate = 1'b1;
        @(negedge clk);
        chk(out_pin, 1'b1, "R5 trigger edge");
        run("R5 pulse", 1, 6, 4);
        gate = 1'b0;
        @(negedge clk);
        chk(out_pin, 1'b0, "R5 pulse continues");
        gate = 1'b1;
        @(negedge clk);
        chk(out_pin, 1'b0, "R5 retrigger edge");
        run("R5 retriggered pulse", 1, 6, 9);

        // R9: strobes
        wctrl(4, 3);
        load16(5);
        run("R9 software strobe", 4, 5, 9);
        load16(1);
        run("R13 strobe count 1", 4, 1, 4);
        gate = 1'b0;
        wctrl(5, 3);
        load16(3);
        repeat (3) begin
            @(negedge clk);
            chk(out_pin, 1'b1, "R9 hardware strobe waits");
        end
        gate = 1'b1;
        @(negedge clk);
        chk(out_pin, 1'b1, "R9 hardware trigger edge");
        run("R9 hardware strobe", 5, 3, 7);

        // R10: low byte halts, high byte restarts
        wctrl(0, 3);
        load16(6);
        run("R10 before halt", 0, 6, 3);
        wreg(2'd0, 8'd3);
        chk(out_pin, 1'b0, "R10 low byte low");
        repeat (10) begin
            @(negedge clk);
            chk(out_pin, 1'b0, "R10 halted");
        end
        wreg(2'd0, 8'd0);
        run("R10 new count", 0, 3, 6);

        // random counts across the level-gated modes
        for (int it = 0; it < 10; it++) begin
            case ($urandom_range(0, 3))
                0:       m = 0;
                1:       m = 2;
                2:       m = 3;
                default: m = 4;
            endcase
            n = $urandom_range(2, 25);
            wctrl(m, 3);
            load16(n);
            case (m)
                0:       run("R4 random", m, n, 3 * n + 2);
                2:       run("R6 random", m, n, 3 * n + 2);
                3:       run("R7 random", m, n, 3 * n + 2);
                default: run("R9 random", m, n, 3 * n + 2);
            endcase
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end

endmodule